// File: doc/BRIEF.md
# Burst Address Sequencer (Linear / Interleaved)

This block produces the address for each beat of a short memory burst. A burst starts when either of two address strobes is seen at a clock edge: the external address is captured, the beat index returns to zero, and the ordering choice present on the order input is captured with it. Each later cycle with the advance input high moves to the next beat. The beat count is a parameter, two bits by default, which gives four beats. Only the low bits that the beat counter covers change during a burst. The upper address bits stay at their loaded value.

Two orderings are supported. The linear order adds the beat index to the starting low bits and wraps. The interleaved order XORs the beat index into the starting low bits. An order input at 0 selects interleaved, which is the inactive level and the default. Bursting is optional: a strobe may arrive on every cycle, and each one takes effect on the next cycle with no lost cycle. The block holds its address and beat index on any cycle with no strobe and no advance.

Top module: `bag_burst_addr`

## Requirements
- R1: When load_a or load_b is high at a rising clock edge, cur_addr equals the ext_addr sampled at that edge after the edge, and beat is 0.
- R2: Strobes on consecutive cycles are each accepted, and each cycle shows the address loaded at the edge before it.
- R3: With no strobe and advance high, beat increments by one modulo 2^BEAT_W (four beats by default). After the last beat it wraps to 0, which puts cur_addr back at the starting address.
- R4: With no strobe and advance low, cur_addr and beat keep their values.
- R5: A strobe has priority over advance in the same cycle: the address is loaded and beat is 0.
- R6: When order_sel was 1 (linear) at the load, the low BEAT_W bits of cur_addr equal (start + beat) modulo 2^BEAT_W.
- R7: When order_sel was 0 (interleaved) at the load, the low BEAT_W bits of cur_addr equal start XOR beat.
- R8: Throughout a burst, the bits of cur_addr above the low BEAT_W bits equal those of the loaded address.
- R9: The order is captured only at a load. Changing order_sel during a burst has no effect until the next load.
- R10: While rst_n is low, cur_addr and beat are 0, and the captured order is interleaved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_a | input | 1 | Address strobe, first source |
| load_b | input | 1 | Address strobe, second source |
| advance | input | 1 | Step to the next beat |
| order_sel | input | 1 | 1 = linear, 0 = interleaved; captured at load |
| ext_addr | input | ADDR_W | Starting address |
| cur_addr | output | ADDR_W | Address of the current beat |
| beat | output | BEAT_W | Beat index within the burst |

## Verification
The assertions take for granted that the strobes, advance, order_sel and ext_addr are stable around each rising edge. They also assume these inputs are known values once reset is released, because a strobe or advance at an edge must resolve to a clear load, step or hold decision. The stimulus changes every input one time unit after a rising edge and holds it until the next edge. It leaves all controls low during reset, so each checked edge sees a single settled command.

// File: rtl/bag_pkg.sv
package bag_pkg;
   typedef enum logic {
      ORD_INTERLEAVE = 1'b0,
      ORD_LINEAR     = 1'b1
   } burst_order_e;
endpackage

// File: rtl/bag_start_reg.sv
module bag_start_reg
   import bag_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] ext_addr,
   input  burst_order_e      order_in,
   output logic [ADDR_W-1:0] base_q,
   output burst_order_e      order_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q  <= '0;
         order_q <= ORD_INTERLEAVE;
      end else if (load) begin
         base_q  <= ext_addr;
         order_q <= order_in;
      end
   end

   // R9: the captured order only moves on a load
   a_r9_order_held: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(order_q));
endmodule

// File: rtl/bag_beat_ctr.sv
module bag_beat_ctr #(
   parameter int BEAT_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              advance,
   output logic [BEAT_W-1:0] beat_q
);
   localparam logic [BEAT_W-1:0] ONE = BEAT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         beat_q <= '0;
      else if (load)
         beat_q <= '0;
      else if (advance)
         beat_q <= beat_q + ONE;
   end

   // R5: load wins over advance
   a_r5_load_first: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> beat_q == '0);
   // R3: single step, wrapping
   a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && advance) |=> beat_q == $past(beat_q) + ONE);
   // R4: idle holds
   a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !advance) |=> $stable(beat_q));
endmodule

// File: rtl/bag_order_map.sv
module bag_order_map
   import bag_pkg::*;
#(
   parameter int BEAT_W = 2
) (
   input  logic [BEAT_W-1:0] start_low,
   input  logic [BEAT_W-1:0] beat,
   input  burst_order_e      order,
   output logic [BEAT_W-1:0] low_out
);
   logic [BEAT_W-1:0] lin_low;
   logic [BEAT_W-1:0] ilv_low;

   // linear: ripple of start + beat, wrapping at 2^BEAT_W
   assign lin_low = start_low + beat;

   // interleaved: each bit flips where the beat bit is set
   genvar gi;
   generate
      for (gi = 0; gi < BEAT_W; gi++) begin : g_ilv
         assign ilv_low[gi] = start_low[gi] ^ beat[gi];
      end
   endgenerate

   always_comb begin
      unique case (order)
         ORD_LINEAR:     low_out = lin_low;
         ORD_INTERLEAVE: low_out = ilv_low;
         default:        low_out = ilv_low;
      endcase
   end
endmodule

// File: rtl/bag_burst_addr.sv
module bag_burst_addr
   import bag_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int BEAT_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_a,
   input  logic              load_b,
   input  logic              advance,
   input  logic              order_sel,
   input  logic [ADDR_W-1:0] ext_addr,
   output logic [ADDR_W-1:0] cur_addr,
   output logic [BEAT_W-1:0] beat
);
   localparam int HI_W = ADDR_W - BEAT_W;

   generate
      if (BEAT_W < 1 || BEAT_W > 8) begin : g_bad_beat
         $error("BEAT_W must be between 1 and 8");
      end
      if (HI_W < 1) begin : g_bad_addr
         $error("ADDR_W must exceed BEAT_W");
      end
   endgenerate

   logic              load_any;
   logic [ADDR_W-1:0] base_q;
   burst_order_e      order_q;
   burst_order_e      order_in;
   logic [BEAT_W-1:0] low_bits;

   assign load_any = load_a | load_b;
   assign order_in = order_sel ? ORD_LINEAR : ORD_INTERLEAVE;

   bag_start_reg #(.ADDR_W(ADDR_W)) u_start (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load_any),
      .ext_addr (ext_addr),
      .order_in (order_in),
      .base_q   (base_q),
      .order_q  (order_q)
   );

   bag_beat_ctr #(.BEAT_W(BEAT_W)) u_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load_any),
      .advance (advance),
      .beat_q  (beat)
   );

   bag_order_map #(.BEAT_W(BEAT_W)) u_map (
      .start_low (base_q[BEAT_W-1:0]),
      .beat      (beat),
      .order     (order_q),
      .low_out   (low_bits)
   );

   assign cur_addr = {base_q[ADDR_W-1:BEAT_W], low_bits};

   // R1: a strobe presents the sampled address on the next cycle
   a_r1_load_addr: assert property (@(posedge clk) disable iff (!rst_n)
      load_any |=> cur_addr == $past(ext_addr));
   // R8: upper bits do not move without a load
   a_r8_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
      !load_any |=> $stable(cur_addr[ADDR_W-1:BEAT_W]));
   // R4: idle cycle keeps the address
   a_r4_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_any && !advance) |=> $stable(cur_addr));
endmodule

// File: tb/tb_bag_burst_addr.sv
`timescale 1ns/1ps
module tb_bag_burst_addr;
   localparam int AW = 16;
   localparam int BW = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          load_a = 1'b0, load_b = 1'b0, advance = 1'b0, order_sel = 1'b0;
   logic [AW-1:0] ext_addr = '0;
   logic [AW-1:0] cur_addr;
   logic [BW-1:0] beat;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #2.5 clk = ~clk;

   bag_burst_addr #(.ADDR_W(AW), .BEAT_W(BW)) dut (
      .clk(clk), .rst_n(rst_n), .load_a(load_a), .load_b(load_b),
      .advance(advance), .order_sel(order_sel), .ext_addr(ext_addr),
      .cur_addr(cur_addr), .beat(beat)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic idle();
      load_a = 0; load_b = 0; advance = 0;
   endtask

   function automatic logic [AW-1:0] expect_addr(input logic [AW-1:0] s,
                                                 input bit lin, input int k);
      logic [BW-1:0] lo;
      lo = lin ? BW'(s[BW-1:0] + BW'(k)) : (s[BW-1:0] ^ BW'(k));
      return {s[AW-1:BW], lo};
   endfunction

   task automatic t_reset();
      #1;
      chk("R10 addr", 32'(cur_addr), 0);
      chk("R10 beat", 32'(beat), 0);
      step();
      rst_n = 1;
      step();
   endtask

   task automatic t_order(input bit lin);
      for (int s = 0; s < 4; s++) begin
         logic [AW-1:0] st;
         st = 16'hA5F0 | 16'(s);
         ext_addr = st; load_a = 1; order_sel = lin;
         step();
         idle();
         ext_addr = 16'h0;
         chk(lin ? "R1 R6 load" : "R1 R7 load", 32'(cur_addr), 32'(st));
         chk("R1 beat", 32'(beat), 0);
         for (int k = 1; k <= 4; k++) begin
            advance = 1;
            step();
            chk(lin ? "R6 R8 R3 linear" : "R7 R8 R3 interleave",
                32'(cur_addr), 32'(expect_addr(st, lin, k & 3)));
            chk("R3 beat", 32'(beat), 32'(k & 3));
         end
         idle();
      end
   endtask

   task automatic t_hold();
      ext_addr = 16'h1236; load_b = 1; order_sel = 1;
      step();
      idle(); advance = 1;
      step();
      idle();
      for (int i = 0; i < 3; i++) begin
         step();
         chk("R4 hold addr", 32'(cur_addr), 32'h1237);
         chk("R4 hold beat", 32'(beat), 1);
      end
   endtask

   task automatic t_priority();
      advance = 1;
      step();
      ext_addr = 16'h4C42; load_a = 1; advance = 1; order_sel = 0;
      step();
      idle();
      chk("R5 addr", 32'(cur_addr), 32'h4C42);
      chk("R5 beat", 32'(beat), 0);
   endtask

   task automatic t_back_to_back();
      for (int i = 0; i < 6; i++) begin
         logic [AW-1:0] a;
         a = 16'(16'h0101 * (i + 3) + i);
         ext_addr = a; order_sel = i[0];
         if (i[0]) load_b = 1; else load_a = 1;
         advance = i[1];
         step();
         chk("R2 consecutive", 32'(cur_addr), 32'(a));
         idle();
      end
   endtask

   task automatic t_sticky();
      ext_addr = 16'h7001; load_a = 1; order_sel = 1;
      step();
      idle(); order_sel = 0;
      for (int k = 1; k <= 3; k++) begin
         advance = 1;
         order_sel = k[0];
         step();
         chk("R9 order kept", 32'(cur_addr), 32'(expect_addr(16'h7001, 1, k)));
      end
      idle();
      ext_addr = 16'h7001; load_b = 1; order_sel = 0;
      step();
      idle(); advance = 1;
      step();
      idle();
      chk("R9 new order at load", 32'(cur_addr), 32'h7000);
   endtask

   initial begin
      t_reset();
      t_order(1'b1);
      t_order(1'b0);
      t_hold();
      t_priority();
      t_back_to_back();
      t_sticky();
      done = 1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule